// File: doc/BRIEF.md
# Deferred Row-Refresh Credit Manager

This block keeps one private bank group's DRAM contents alive without the device's built-in refresh command. A divider on a shared tick timebase earns one refresh credit per interval. The interval is set a little shorter than the retention period divided by the number of rows. The spare credits give the block room to postpone refresh work. Each refresh is an ordinary row activate followed by a precharge on the row named by `row_o`. The scheduler issues it in the group's own time slot.

While the group is in a multi-burst transaction (`txn_active_i` high), the block holds back its request and lets credits build up. It asks again once the transaction ends. Credits are kept in a saturating counter. When the counter is full, `force_o` rises and the request is raised even during a transaction, so that no row misses its retention deadline. A granted refresh uses up one credit and moves the row pointer to the next row. The pointer wraps after the last row.

Top module: `rfm_refresh_mgr`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `refresh_req_o` and `force_o` are 0 and `row_o` is 0.
- R2: One credit is earned on every INTERVAL-th cycle that has `tick_i` high. Cycles with `tick_i` low do not advance the interval count.
- R3: With at least one credit and `txn_active_i` low, `refresh_req_o` is 1 in the same cycle.
- R4: With `txn_active_i` high and the credit count below CREDIT_MAX, `refresh_req_o` is 0. A `slot_grant_i` in that cycle changes neither `row_o` nor the credit count.
- R5: `force_o` is 1 exactly when the credit count equals CREDIT_MAX. While `force_o` is 1, `refresh_req_o` is 1 whatever the value of `txn_active_i`.
- R6: A cycle with `slot_grant_i` and `refresh_req_o` both high is a granted refresh. After that clock edge, `row_o` is one higher and the credit count is one lower, plus any credit earned in the same cycle.
- R7: A granted refresh at row ROWS-1 moves `row_o` to 0. `row_o` never reaches ROWS or above.
- R8: The credit count never goes above CREDIT_MAX. A credit earned while the count is full and no refresh is granted is dropped.
- R9: `row_o` changes only on the clock edge that follows a granted refresh.
- R10: A `slot_grant_i` with zero credits has no effect on `row_o` or on later request timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase strobe; each high cycle counts toward a credit |
| txn_active_i | input | 1 | The group is inside a multi-burst transaction |
| slot_grant_i | input | 1 | The scheduler offers the group's slot this cycle |
| refresh_req_o | output | 1 | A refresh read is requested for `row_o` |
| force_o | output | 1 | Credits are full; the refresh must be honoured now |
| row_o | output | RW | Row targeted by the next refresh read |

## Verification
The credit count has no port of its own, so the checks read it through its effects. A wrong count shows up as a request that stays high after the expected number of grants, a request that drops too early, or `force_o` rising on the wrong tick. A phase error in the interval divider moves the first request after a run of ticks by whole tick periods. A row pointer that steps wrongly or wraps at the wrong value shows on `row_o` on the very next edge after a grant. Because of this, every state is compared against a behavioural model on every cycle, so a fault is reported within one cycle of reaching the ports.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  // Next row pointer after a granted refresh, wrapping at the row count.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Credit count after one cycle: add earned, subtract spent, clamp at max.
  function automatic int unsigned credit_step(input int unsigned cur, input bit earn,
                                              input bit spend, input int unsigned cap);
    int unsigned s;
    s = cur + (earn ? 1 : 0);
    if (spend && s != 0) s = s - 1;
    return (s > cap) ? cap : s;
  endfunction

endpackage

// File: rtl/rfm_interval.sv
module rfm_interval #(
  parameter int unsigned INTERVAL = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic earn_o
);
  localparam int unsigned IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [IW-1:0] phase_q;
  logic          at_end;

  assign at_end = (phase_q == IW'(INTERVAL - 1));
  assign earn_o = tick_i && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (earn_o)   phase_q <= '0;
    else if (tick_i)   phase_q <= phase_q + 1'b1;
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_q) < INTERVAL);

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(phase_q));

endmodule

// File: rtl/rfm_credits.sv
module rfm_credits #(
  parameter int unsigned CREDIT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic earn_i,
  input  logic spend_i,
  output logic any_o,
  output logic full_o
);
  localparam int unsigned CW = $clog2(CREDIT_MAX + 1);

  logic [CW-1:0] cred_q;
  logic [CW-1:0] cred_d;

  always_comb begin
    cred_d = CW'(rfm_pkg::credit_step(32'(cred_q), earn_i, spend_i, CREDIT_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cred_q <= '0;
    else        cred_q <= cred_d;
  end

  assign any_o  = (cred_q != '0);
  assign full_o = (32'(cred_q) == CREDIT_MAX);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cred_q) <= CREDIT_MAX);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spend_i |-> cred_q != '0);

  // R2
  grow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_q > $past(cred_q)) |-> $past(earn_i));

endmodule

// File: rtl/rfm_row_walker.sv
module rfm_row_walker #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned RW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [RW-1:0] row_o
);
  logic [RW-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     row_q <= '0;
    else if (adv_i) row_q <= RW'(rfm_pkg::wrap_inc(32'(row_q), ROWS));
  end

  assign row_o = row_q;

  // R7
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_q) < ROWS);

  // R9
  row_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(row_q));

endmodule

// File: rtl/rfm_refresh_mgr.sv
module rfm_refresh_mgr #(
  parameter int unsigned ROWS       = 16,
  parameter int unsigned INTERVAL   = 5,
  parameter int unsigned CREDIT_MAX = 8,
  localparam int unsigned RW        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          txn_active_i,
  input  logic          slot_grant_i,
  output logic          refresh_req_o,
  output logic          force_o,
  output logic [RW-1:0] row_o
);
  logic earn;
  logic any_credit;
  logic full_credit;
  logic granted;

  rfm_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .earn_o(earn)
  );

  rfm_credits #(.CREDIT_MAX(CREDIT_MAX)) u_credits (
    .clk(clk), .rst_n(rst_n), .earn_i(earn), .spend_i(granted),
    .any_o(any_credit), .full_o(full_credit)
  );

  rfm_row_walker #(.ROWS(ROWS), .RW(RW)) u_rows (
    .clk(clk), .rst_n(rst_n), .adv_i(granted), .row_o(row_o)
  );

  assign force_o       = full_credit;
  assign refresh_req_o = any_credit && (!txn_active_i || full_credit);
  assign granted       = slot_grant_i && refresh_req_o;

  // R4
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req_o && txn_active_i) |-> force_o);

  // R5
  force_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_o |-> refresh_req_o);

  // R6
  grant_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && 32'(row_o) < ROWS - 1) |=> 32'(row_o) == 32'($past(row_o)) + 1);

endmodule

// File: tb/rfm_refresh_mgr_tb.sv
module rfm_refresh_mgr_tb;
  localparam int ROWS = 16;
  localparam int INTV = 5;
  localparam int CMAX = 8;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0, txn = 0, grant = 0;
  logic       req, frc;
  logic [3:0] row;

  int vectors = 0, errors = 0;
  int m_phase = 0, m_cred = 0, m_row = 0;

  always #2 clk = ~clk;

  rfm_refresh_mgr #(.ROWS(ROWS), .INTERVAL(INTV), .CREDIT_MAX(CMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .txn_active_i(txn),
    .slot_grant_i(grant), .refresh_req_o(req), .force_o(frc), .row_o(row)
  );

  task automatic compare(input string tag);
    bit e_frc, e_req;
    e_frc = (m_cred == CMAX);
    e_req = (m_cred > 0) && (!txn || e_frc);
    vectors++;
    if (req !== e_req) begin
      errors++; $display("FAIL %s/R3 req got %0b exp %0b", tag, req, e_req);
    end
    if (frc !== e_frc) begin
      errors++; $display("FAIL %s/R5 force got %0b exp %0b", tag, frc, e_frc);
    end
    if (int'(row) !== m_row) begin
      errors++; $display("FAIL %s/R6 row got %0d exp %0d", tag, row, m_row);
    end
  endtask

  task automatic step(input bit t, input bit x, input bit g, input string tag);
    bit earn, done, e_req;
    @(negedge clk);
    tick = t; txn = x; grant = g;
    #1;
    compare(tag);
    e_req = (m_cred > 0) && (!x || m_cred == CMAX);
    earn = t && (m_phase == INTV - 1);
    done = g && e_req;
    if (t) m_phase = earn ? 0 : m_phase + 1;
    m_cred = m_cred + (earn ? 1 : 0) - (done ? 1 : 0);
    if (m_cred > CMAX) m_cred = CMAX;
    if (done) m_row = (m_row + 1) % ROWS;
    @(posedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog R1 got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    compare("R1_reset");
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, "R1_first");

    // R2: ticks interleaved with idle cycles; a credit every 5th tick
    for (int i = 0; i < 14; i++) step(i % 3 != 2, 0, 0, "R2_earn");
    for (int i = 0; i < 12; i++) step(1, 0, 0, "R3_req");

    // R6, R10: drain credits, then keep granting with none left
    for (int i = 0; i < 10; i++) step(0, 0, 1, "R10_drain");

    // R4: transaction active, grants offered, credits build up (deferred)
    for (int i = 0; i < 38; i++) step(1, 1, 1, "R4_defer");
    // R5: reach full, forced refresh taken despite transaction
    for (int i = 0; i < 8; i++) step(1, 1, 0, "R5_force");
    step(0, 1, 1, "R5_forced_grant");

    // R8: saturate while blocked, then drain exactly CMAX
    for (int i = 0; i < 60; i++) step(1, 1, 0, "R8_sat");
    for (int i = 0; i < 12; i++) step(0, 0, 1, "R8_drain");

    // R7, R9: mixed traffic long enough to wrap the row pointer many times
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 1), "R7_mix");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule